// File: doc/BRIEF.md
# Phase Build-Out Offset Controller

This block sets the phase offset that a digital PLL puts into its feedback path. With build-out turned on, the block reacts to a reference switch or to the PLL leaving free-run or a holdover state. In each case it takes the measured phase difference between the new reference and the output, adds a small programmable bias, and stores the sum as the offset. The output then keeps its phase, and the loop does not pull it to zero.

With build-out turned off, the loop aims at the manual offset instead. A freeze control blocks all captures and keeps the stored offset. Manual-offset writes made while the PLL is in free-run or holdover are held back until the PLL starts locking. The output target moves toward its goal by at most a programmable step per clock.

Top module: `phase_buildout_ctrl`

## Requirements
- R1: After reset, `target` is 0 and both `bld_event` and `tmp_hold` are low.
- R2: While `bld_en` is low, a reference switch raises neither `bld_event` nor `tmp_hold`. The goal of `target` is then the applied manual offset, a signed two's-complement code.
- R3: With `bld_en` high and `bld_hold` low, a one-cycle `ref_switch` raises `tmp_hold` and `bld_event` together for exactly the next cycle. The stored offset becomes `phase_err + bld_bias`, and `target` ramps to it.
- R4: With build-out armed, a change of `pll_mode` into a tracking mode captures the offset and pulses `bld_event` in the next cycle. The tracking modes are 3 (locking) and 4 (locked); the holding modes are 0 (free-run), 1 (holdover) and 2 (mini-holdover). Staying in a holding mode captures nothing.
- R5: While `bld_hold` is high, reference switches and mode changes produce no event, and the stored offset and `target` stay unchanged.
- R6: Raising `bld_en` or dropping `bld_hold` while the mode is tracking (with build-out armed afterwards) counts as a capture and pulses `bld_event`.
- R7: Lowering `bld_en` while tracking moves `target` back to the applied manual offset (zero when the manual offset is zero), at the step rate, with no event.
- R8: `man_ofs` is copied into the applied manual offset only in cycles whose mode is tracking. Changes made in a holding mode leave `target` unchanged until the mode becomes tracking.
- R9: From one cycle to the next, `target` changes by at most `step_max`. Once the remaining distance to the goal is no larger than `step_max`, `target` lands exactly on the goal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_mode | input | 3 | PLL mode: 0 free-run, 1 holdover, 2 mini-holdover, 3 locking, 4 locked |
| ref_switch | input | 1 | One-cycle pulse: selected reference failed, alternative chosen |
| phase_err | input | PH_W (16) | Signed measured phase difference, new reference to output |
| bld_en | input | 1 | Build-out enable |
| bld_hold | input | 1 | Freeze: ignore captures, keep stored offset |
| bld_bias | input | BIAS_W (8) | Signed bias added on each capture |
| man_ofs | input | MAN_W (15) | Signed manual offset, used while build-out is off |
| step_max | input | STEP_W (12) | Largest change of `target` per clock |
| target | output | OFS_W (18) | Signed total phase-offset target for the loop |
| bld_event | output | 1 | One-cycle pulse per offset capture |
| tmp_hold | output | 1 | One-cycle temporary-holdover request after an armed reference switch |

## Verification
A capture is registered at the first rising edge that sees its trigger. `bld_event`, `tmp_hold` and the stored offset therefore change at that edge, and `target` takes its first step one edge later. A manual-offset change follows the same schedule: it is applied at the first tracking edge and moves `target` from the edge after that. The bench drives and samples on falling edges. It checks the pulse at the first falling edge after the trigger, checks the first ramp step at the second, and checks final values only after enough edges for the distance divided by the step.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    typedef enum logic [2:0] {
        MODE_FREERUN  = 3'd0,
        MODE_HOLDOVER = 3'd1,
        MODE_MINIHOLD = 3'd2,
        MODE_LOCKING  = 3'd3,
        MODE_LOCKED   = 3'd4
    } pll_mode_e;

    function automatic logic is_tracking(input logic [2:0] mode);
        return (mode == MODE_LOCKING) || (mode == MODE_LOCKED);
    endfunction

endpackage

// File: rtl/pbc_trigger.sv
module pbc_trigger
    import pbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] pll_mode,
    input  logic       ref_switch,
    input  logic       bld_en,
    input  logic       bld_hold,
    output logic       capture,
    output logic       tmp_hold
);

    typedef struct packed {
        logic trk;
        logic en;
        logic frz;
        logic hold;
    } trig_t;

    trig_t st_d, st_q;
    logic  trk_now;
    logic  armed;

    always_comb begin
        trk_now = is_tracking(pll_mode);
        armed   = bld_en & ~bld_hold;
        // switch, leaving a holding mode, enable rise, freeze release
        capture = armed & (ref_switch
                         | (trk_now & ~st_q.trk)
                         | (trk_now & ~st_q.en)
                         | (trk_now &  st_q.frz));
        st_d.trk  = trk_now;
        st_d.en   = bld_en;
        st_d.frz  = bld_hold;
        st_d.hold = armed & ref_switch;
        tmp_hold  = st_q.hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pbc_slew.sv
module pbc_slew #(
    parameter int OFS_W  = 18,
    parameter int STEP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [OFS_W-1:0] goal,
    input  logic [STEP_W-1:0]       step_max,
    output logic signed [OFS_W-1:0] target
);

    localparam int DW = OFS_W + 1;

    logic signed [OFS_W-1:0] tgt_d, tgt_q;
    logic signed [DW-1:0]    goal_x, tgt_x, diff, stp;

    always_comb begin
        goal_x = {goal[OFS_W-1], goal};
        tgt_x  = {tgt_q[OFS_W-1], tgt_q};
        diff   = goal_x - tgt_x;
        stp    = {{(DW-STEP_W){1'b0}}, step_max};
        if (diff > stp) begin
            tgt_d = tgt_q + stp[OFS_W-1:0];
        end else if (diff < -stp) begin
            tgt_d = tgt_q - stp[OFS_W-1:0];
        end else begin
            tgt_d = goal;
        end
        target = tgt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else begin
            tgt_q <= tgt_d;
        end
    end

endmodule

// File: rtl/phase_buildout_ctrl.sv
module phase_buildout_ctrl
    import pbc_pkg::*;
#(
    parameter int PH_W   = 16,
    parameter int MAN_W  = 15,
    parameter int BIAS_W = 8,
    parameter int OFS_W  = 18,
    parameter int STEP_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               pll_mode,
    input  logic                     ref_switch,
    input  logic signed [PH_W-1:0]   phase_err,
    input  logic                     bld_en,
    input  logic                     bld_hold,
    input  logic signed [BIAS_W-1:0] bld_bias,
    input  logic signed [MAN_W-1:0]  man_ofs,
    input  logic [STEP_W-1:0]        step_max,
    output logic signed [OFS_W-1:0]  target,
    output logic                     bld_event,
    output logic                     tmp_hold
);

    typedef struct packed {
        logic [OFS_W-1:0] acc;
        logic [OFS_W-1:0] man;
        logic             evt;
    } ctl_t;

    ctl_t st_d, st_q;

    logic                    capture;
    logic signed [OFS_W-1:0] err_x, bias_x, man_x, goal;

    pbc_trigger u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_mode   (pll_mode),
        .ref_switch (ref_switch),
        .bld_en     (bld_en),
        .bld_hold   (bld_hold),
        .capture    (capture),
        .tmp_hold   (tmp_hold)
    );

    always_comb begin
        err_x  = OFS_W'(phase_err);
        bias_x = OFS_W'(bld_bias);
        man_x  = OFS_W'(man_ofs);
        st_d   = st_q;
        if (capture) begin
            st_d.acc = err_x + bias_x;
        end
        if (is_tracking(pll_mode)) begin
            st_d.man = man_x;
        end
        st_d.evt  = capture;
        goal      = bld_en ? signed'(st_q.acc) : signed'(st_q.man);
        bld_event = st_q.evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pbc_slew #(
        .OFS_W  (OFS_W),
        .STEP_W (STEP_W)
    ) u_slew (
        .clk      (clk),
        .rst_n    (rst_n),
        .goal     (goal),
        .step_max (step_max),
        .target   (target)
    );

endmodule

// File: rtl/phase_buildout_chk.sv
module phase_buildout_chk
    import pbc_pkg::*;
#(
    parameter int OFS_W  = 18,
    parameter int STEP_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              pll_mode,
    input logic                    ref_switch,
    input logic                    bld_en,
    input logic                    bld_hold,
    input logic [STEP_W-1:0]       step_max,
    input logic signed [OFS_W-1:0] target,
    input logic                    bld_event,
    input logic                    tmp_hold
);

    logic [OFS_W-1:0]  prev_t;
    logic [STEP_W-1:0] prev_s;
    logic              valid, prev_trk, prev_en, trk;
    logic [OFS_W:0]    dlt, mag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_t   <= '0;
            prev_s   <= '0;
            valid    <= 1'b0;
            prev_trk <= 1'b0;
            prev_en  <= 1'b0;
        end else begin
            prev_t   <= target;
            prev_s   <= step_max;
            valid    <= 1'b1;
            prev_trk <= trk;
            prev_en  <= bld_en;
        end
    end

    always_comb begin
        trk = is_tracking(pll_mode);
        dlt = {target[OFS_W-1], target} - {prev_t[OFS_W-1], prev_t};
        mag = dlt[OFS_W] ? -dlt : dlt;
    end

    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (mag <= (OFS_W+1)'(prev_s))); // R9
    AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bld_hold |=> !bld_event); // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bld_en |=> (!bld_event && !tmp_hold)); // R2
    AST_SWITCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_switch && bld_en && !bld_hold) |=> (tmp_hold && bld_event)); // R3
    AST_HOLD_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        tmp_hold |-> bld_event); // R3
    AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bld_en && !bld_hold && trk && !prev_trk) |=> bld_event); // R4
    AST_ENABLE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (bld_en && !prev_en && !bld_hold && trk) |=> bld_event); // R6

endmodule

bind phase_buildout_ctrl phase_buildout_chk #(
    .OFS_W  (OFS_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_mode   (pll_mode),
    .ref_switch (ref_switch),
    .bld_en     (bld_en),
    .bld_hold   (bld_hold),
    .step_max   (step_max),
    .target     (target),
    .bld_event  (bld_event),
    .tmp_hold   (tmp_hold)
);

// File: tb/sim_phase_buildout_ctrl.sv
module sim_phase_buildout_ctrl;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [2:0]         pll_mode;
    logic               ref_switch;
    logic signed [15:0] phase_err;
    logic               bld_en;
    logic               bld_hold;
    logic signed [7:0]  bld_bias;
    logic signed [14:0] man_ofs;
    logic [11:0]        step_max;
    logic signed [17:0] target;
    logic               bld_event;
    logic               tmp_hold;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    phase_buildout_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pll_mode   (pll_mode),
        .ref_switch (ref_switch),
        .phase_err  (phase_err),
        .bld_en     (bld_en),
        .bld_hold   (bld_hold),
        .bld_bias   (bld_bias),
        .man_ofs    (man_ofs),
        .step_max   (step_max),
        .target     (target),
        .bld_event  (bld_event),
        .tmp_hold   (tmp_hold)
    );

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; pll_mode = 3'd0; ref_switch = 1'b0; phase_err = '0;
        bld_en = 1'b0; bld_hold = 1'b0; bld_bias = '0; man_ofs = '0;
        step_max = 12'd100;
        cyc(3);
        rst_n = 1'b1;
        chk("R1 target", int'(target), 0);
        chk("R1 event", int'(bld_event), 0);
        chk("R1 tmp_hold", int'(tmp_hold), 0);
        cyc(1);
        chk("R1 target after release", int'(target), 0);
    endtask

    task automatic t_disabled;
        man_ofs = 15'sd250; pll_mode = 3'd4;
        cyc(1);
        chk("R2 target first edge", int'(target), 0);
        cyc(1);
        chk("R9 first step", int'(target), 100);
        cyc(2);
        chk("R2 manual reached", int'(target), 250);
        phase_err = 16'sd77; ref_switch = 1'b1;
        cyc(1);
        chk("R2 no event", int'(bld_event), 0);
        chk("R2 no tmp_hold", int'(tmp_hold), 0);
        ref_switch = 1'b0;
        cyc(1);
        chk("R2 target kept", int'(target), 250);
    endtask

    task automatic t_defer;
        pll_mode = 3'd1; man_ofs = -15'sd300;
        cyc(5);
        chk("R8 deferred in holdover", int'(target), 250);
        pll_mode = 3'd3;
        cyc(1);
        chk("R8 not yet moved", int'(target), 250);
        cyc(8);
        chk("R8 applied after locking", int'(target), -300);
    endtask

    task automatic t_enable;
        phase_err = 16'sd40; bld_bias = 8'sd3; bld_en = 1'b1;
        cyc(1);
        chk("R6 enable event", int'(bld_event), 1);
        chk("R6 no tmp_hold", int'(tmp_hold), 0);
        cyc(1);
        chk("R6 event one cycle", int'(bld_event), 0);
        cyc(8);
        chk("R6 target captured", int'(target), 43);
    endtask

    task automatic t_switch;
        pll_mode = 3'd4; phase_err = -16'sd500; ref_switch = 1'b1;
        cyc(1);
        chk("R3 event", int'(bld_event), 1);
        chk("R3 tmp_hold", int'(tmp_hold), 1);
        ref_switch = 1'b0;
        cyc(1);
        chk("R3 event ends", int'(bld_event), 0);
        chk("R3 tmp_hold ends", int'(tmp_hold), 0);
        chk("R9 step down", int'(target), -57);
        cyc(10);
        chk("R3 target with bias", int'(target), -497);
    endtask

    task automatic t_freeze;
        bld_hold = 1'b1; phase_err = 16'sd999; ref_switch = 1'b1;
        cyc(1);
        chk("R5 no event on switch", int'(bld_event), 0);
        chk("R5 no tmp_hold", int'(tmp_hold), 0);
        ref_switch = 1'b0; pll_mode = 3'd1;
        cyc(1);
        pll_mode = 3'd4;
        cyc(1);
        chk("R5 no event on lock", int'(bld_event), 0);
        cyc(4);
        chk("R5 offset held", int'(target), -497);
        phase_err = 16'sd200; bld_bias = -8'sd5; bld_hold = 1'b0;
        cyc(1);
        chk("R6 release event", int'(bld_event), 1);
        cyc(10);
        chk("R6 release target", int'(target), 195);
    endtask

    task automatic t_exit;
        man_ofs = '0; pll_mode = 3'd1;
        cyc(3);
        chk("R4 no event in holdover", int'(bld_event), 0);
        chk("R4 target kept", int'(target), 195);
        phase_err = -16'sd60; pll_mode = 3'd3;
        cyc(1);
        chk("R4 holdover exit event", int'(bld_event), 1);
        chk("R4 no tmp_hold", int'(tmp_hold), 0);
        cyc(5);
        chk("R4 target after exit", int'(target), -65);
        pll_mode = 3'd2;
        cyc(1);
        phase_err = 16'sd700; bld_bias = '0; pll_mode = 3'd4;
        cyc(1);
        chk("R4 mini-holdover exit event", int'(bld_event), 1);
        cyc(12);
        chk("R4 target after mini exit", int'(target), 700);
    endtask

    task automatic t_disable;
        bld_en = 1'b0;
        cyc(1);
        chk("R7 no event", int'(bld_event), 0);
        chk("R7 first step", int'(target), 600);
        cyc(10);
        chk("R7 back to zero", int'(target), 0);
    endtask

    task automatic t_big_step;
        step_max = 12'd1000; man_ofs = -15'sd2000;
        cyc(1);
        chk("R9 first edge", int'(target), 0);
        cyc(1);
        chk("R9 large step", int'(target), -1000);
        cyc(1);
        chk("R9 lands on goal", int'(target), -2000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_disabled();
        t_defer();
        t_enable();
        t_switch();
        t_freeze();
        t_exit();
        t_disable();
        t_big_step();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule